// File: doc/BRIEF.md
# Replicated Branch Condition Classifier

This block turns a comparison between two replicated operand vectors into a branch decision that also exposes disagreement between the replicas. Each vector carries several copies of the same value, one per lane, at a selectable element width. Every lane compares its pair of elements and produces a mask element that is all ones when the comparison holds and all zeros when it does not. A flag stage then reduces the mask against a test vector. The zero flag reports an empty AND of mask and test vector. The carry flag reports an empty AND of the inverted mask with the test vector.

On fault-free operands every lane sees the same pair of values, so with an all-ones test vector the mask is either entirely true or entirely false. A mask that mixes true and false lanes leaves both flags clear. This state is reported as a recover request in place of a taken or not-taken decision. The fault check therefore comes out of the same two flags that decide the branch, and no separate horizontal compare is needed. One request is accepted per cycle, and the result is registered and presented on the next cycle.

Top module: `branch_classifier`

## Requirements
- R1: While reset is high and on the first cycle after it, res_valid, take_br, skip_br, recover, zf and cf are all 0.
- R2: With cmp_op = 0 (equal), a lane's mask element is all ones when its two elements are equal and all zeros otherwise. The lane width is set by elem_sel: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane i occupies bits [i*w +: w].
- R3: With cmp_op = 1, a lane is true when its op_a element is greater than its op_b element, both read as two's complement numbers.
- R4: With cmp_op = 2, a lane is true when its op_a element is greater than its op_b element, both read as unsigned numbers. With cmp_op = 3, every lane is false.
- R5: One cycle after a request, zf is 1 exactly when (mask AND tst_vec) is zero, and cf is 1 exactly when (NOT mask AND tst_vec) is zero.
- R6: For an accepted request, take_br equals cf, skip_br is zf AND NOT cf, and recover is NOT zf AND NOT cf. When res_valid is 1, exactly one of the three is 1.
- R7: res_valid equals req_valid delayed by one cycle. When res_valid is 0, all three decision outputs are 0, and zf and cf keep their values from the last request.
- R8: With tst_vec all ones, operands whose lanes all hold identical pairs never raise recover. Flipping one bit of one lane under the equal comparison raises recover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one classification per cycle |
| cmp_op | input | 2 | Comparison: 0 equal, 1 signed greater, 2 unsigned greater, 3 never true |
| elem_sel | input | 2 | Lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| op_a | input | VEC_W | First replicated operand vector |
| op_b | input | VEC_W | Second replicated operand vector |
| tst_vec | input | VEC_W | Test vector for the flag reduction |
| res_valid | output | 1 | Result valid, one cycle after req_valid |
| take_br | output | 1 | Branch taken (carry flag set) |
| skip_br | output | 1 | Branch not taken (zero flag only) |
| recover | output | 1 | Mixed mask, replicas disagree |
| zf | output | 1 | Registered zero flag |
| cf | output | 1 | Registered carry flag |

## Verification
The assertions make no assumption about the inputs beyond a known level on req_valid once reset is released. The decision encoding is checked for any test vector, including a zero vector that sets both flags. The properties that tie operands to a decision hold for any lane width, because equal operands give a uniform mask. The stimulus mostly builds fault-free vectors by repeating one random element across all lanes. Some requests flip a single bit in one lane, and others use a partial test vector. A bench function recomputes the mask lane by lane as the reference.

// File: rtl/branch_classifier_pkg.sv
package branch_classifier_pkg;
  typedef enum logic [1:0] {
    CMP_EQ   = 2'd0,
    CMP_SGT  = 2'd1,
    CMP_UGT  = 2'd2,
    CMP_NONE = 2'd3
  } cmp_op_e;

  localparam int unsigned NUM_WIDTHS = 4;
  localparam int unsigned MIN_ELEM_W = 8;

  typedef struct packed {
    logic zf;
    logic cf;
    logic take;
    logic skip;
    logic recover;
  } flag_res_t;
endpackage

// File: rtl/lane_cmp.sv
module lane_cmp
  import branch_classifier_pkg::*;
#(
  parameter int unsigned ELEM_W = 8
) (
  input  logic [ELEM_W-1:0] a_el,
  input  logic [ELEM_W-1:0] b_el,
  input  cmp_op_e           op,
  output logic [ELEM_W-1:0] mask_el
);
  logic hit;

  always_comb begin
    unique case (op)
      CMP_EQ:  hit = (a_el == b_el);
      CMP_SGT: hit = ($signed(a_el) > $signed(b_el));
      CMP_UGT: hit = (a_el > b_el);
      default: hit = 1'b0;
    endcase
    mask_el = {ELEM_W{hit}};
  end
endmodule

// File: rtl/cmp_array.sv
module cmp_array
  import branch_classifier_pkg::*;
#(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  cmp_op_e          op,
  output logic [VEC_W-1:0] mask
);
  localparam int unsigned LANES = VEC_W / ELEM_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_cmp #(.ELEM_W(ELEM_W)) u_lane (
      .a_el   (op_a[l*ELEM_W +: ELEM_W]),
      .b_el   (op_b[l*ELEM_W +: ELEM_W]),
      .op     (op),
      .mask_el(mask[l*ELEM_W +: ELEM_W])
    );
  end
endmodule

// File: rtl/flag_reduce.sv
module flag_reduce
  import branch_classifier_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic [VEC_W-1:0] mask,
  input  logic [VEC_W-1:0] tst_vec,
  output flag_res_t        res
);
  always_comb begin
    res.zf      = ~|(mask & tst_vec);
    res.cf      = ~|(~mask & tst_vec);
    res.take    = res.cf;
    res.skip    = res.zf & ~res.cf;
    res.recover = ~res.zf & ~res.cf;
  end
endmodule

// File: rtl/branch_classifier.sv
module branch_classifier
  import branch_classifier_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       cmp_op,
  input  logic [1:0]       elem_sel,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [VEC_W-1:0] tst_vec,
  output logic             res_valid,
  output logic             take_br,
  output logic             skip_br,
  output logic             recover,
  output logic             zf,
  output logic             cf
);
  cmp_op_e          op_q;
  logic [VEC_W-1:0] mask_by_w [NUM_WIDTHS];
  logic [VEC_W-1:0] mask_sel;
  flag_res_t        fr;

  assign op_q = cmp_op_e'(cmp_op);

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int unsigned EW = MIN_ELEM_W << g;
    cmp_array #(.VEC_W(VEC_W), .ELEM_W(EW)) u_arr (
      .op_a(op_a),
      .op_b(op_b),
      .op  (op_q),
      .mask(mask_by_w[g])
    );
  end

  assign mask_sel = mask_by_w[elem_sel];

  flag_reduce #(.VEC_W(VEC_W)) u_flags (
    .mask   (mask_sel),
    .tst_vec(tst_vec),
    .res    (fr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      take_br   <= 1'b0;
      skip_br   <= 1'b0;
      recover   <= 1'b0;
      zf        <= 1'b0;
      cf        <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        zf      <= fr.zf;
        cf      <= fr.cf;
        take_br <= fr.take;
        skip_br <= fr.skip;
        recover <= fr.recover;
      end else begin
        take_br <= 1'b0;
        skip_br <= 1'b0;
        recover <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/branch_classifier_chk.sv
module branch_classifier_chk #(
  parameter int unsigned VEC_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       cmp_op,
  input logic [VEC_W-1:0] op_a,
  input logic [VEC_W-1:0] op_b,
  input logic [VEC_W-1:0] tst_vec,
  input logic             res_valid,
  input logic             take_br,
  input logic             skip_br,
  input logic             recover,
  input logic             zf,
  input logic             cf
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    res_valid == $past(req_valid));

  // R6
  one_decision_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({take_br, skip_br, recover}) == 1);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ({take_br, skip_br, recover} == 3'b000));

  // R6
  recover_flags_chk: assert property (@(posedge clk) disable iff (rst)
    recover |-> (!zf && !cf));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(req_valid) |-> ($stable(zf) && $stable(cf)));

  // R8
  equal_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cmp_op == 2'd0 && op_a == op_b && (&tst_vec)) |=> take_br);

  // R3
  gt_equal_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cmp_op != 2'd0 && op_a == op_b && (|tst_vec)) |=> skip_br);
endmodule

bind branch_classifier branch_classifier_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/branch_classifier_tb.sv
module branch_classifier_tb;
  localparam int unsigned VW = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    cmp_op;
  logic [1:0]    elem_sel;
  logic [VW-1:0] op_a, op_b, tst_vec;
  logic          res_valid, take_br, skip_br, recover, zf, cf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  branch_classifier #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cmp_op(cmp_op),
    .elem_sel(elem_sel), .op_a(op_a), .op_b(op_b), .tst_vec(tst_vec),
    .res_valid(res_valid), .take_br(take_br), .skip_br(skip_br),
    .recover(recover), .zf(zf), .cf(cf)
  );

  function automatic logic [VW-1:0] ref_mask(logic [VW-1:0] a, logic [VW-1:0] b,
                                             logic [1:0] op, logic [1:0] sel);
    logic [VW-1:0] m;
    logic [63:0]   lm, sb, x, y;
    int            w;
    bit            hit;
    w  = 8 << sel;
    lm = (sel == 2'd3) ? '1 : ((64'd1 << w) - 64'd1);
    sb = 64'd1 << (w - 1);
    m  = '0;
    for (int i = 0; i < VW / w; i++) begin
      x = 64'(a >> (i * w)) & lm;
      y = 64'(b >> (i * w)) & lm;
      case (op)
        2'd0:    hit = (x == y);
        2'd1:    hit = ((x ^ sb) > (y ^ sb));
        2'd2:    hit = (x > y);
        default: hit = 1'b0;
      endcase
      if (hit) m = m | (VW'(lm) << (i * w));
    end
    return m;
  endfunction

  function automatic logic [VW-1:0] rep(logic [63:0] v, logic [1:0] sel);
    logic [VW-1:0] r;
    logic [63:0]   lm;
    int            w;
    w  = 8 << sel;
    lm = (sel == 2'd3) ? '1 : ((64'd1 << w) - 64'd1);
    r  = '0;
    for (int i = 0; i < VW / w; i++) r = r | (VW'(v & lm) << (i * w));
    return r;
  endfunction

  task automatic chk(string req, string name, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
    end
  endtask

  // drive one request at a negedge, check at the following negedge
  task automatic run(string req, logic [1:0] op, logic [1:0] sel,
                     logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] t);
    logic [VW-1:0] m;
    logic ezf, ecf;
    m   = ref_mask(a, b, op, sel);
    ezf = ((m & t) == '0);
    ecf = ((~m & t) == '0);
    req_valid = 1'b1; cmp_op = op; elem_sel = sel;
    op_a = a; op_b = b; tst_vec = t;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "res_valid", res_valid, 1'b1);
    chk(req, "zf", zf, ezf);
    chk(req, "cf", cf, ecf);
    chk(req, "take_br", take_br, ecf);
    chk(req, "skip_br", skip_br, ezf & ~ecf);
    chk(req, "recover", recover, ~ezf & ~ecf);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] ones, va, vb, tv;
    logic [63:0]   e;
    logic [1:0]    s, o;
    logic          hz, hc;
    int            seed_dummy;
    ones = '1;
    seed_dummy = $urandom(32'd1234);
    rst = 1'b1; req_valid = 1'b0; cmp_op = '0; elem_sel = '0;
    op_a = '0; op_b = '0; tst_vec = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", res_valid, 1'b0);
    chk("R1", "take_br", take_br, 1'b0);
    chk("R1", "zf", zf, 1'b0);
    chk("R1", "cf", cf, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "res_valid_post", res_valid, 1'b0);
    chk("R1", "recover_post", recover, 1'b0);

    // R2: equal at every width, both outcomes
    for (int w = 0; w < 4; w++) begin
      run("R2", 2'd0, 2'(w), rep(64'h1234_5678_9ABC_DEF0, 2'(w)),
          rep(64'h1234_5678_9ABC_DEF0, 2'(w)), ones);
      run("R2", 2'd0, 2'(w), rep(64'h1111, 2'(w)), rep(64'h2222, 2'(w)), ones);
    end
    // R3: signed: 0x80 is negative, so not greater than 0x01
    run("R3", 2'd1, 2'd0, rep(64'h80, 2'd0), rep(64'h01, 2'd0), ones);
    chk("R3", "sgt_neg_skip", skip_br, 1'b1);
    run("R3", 2'd1, 2'd3, rep(64'h1, 2'd3), rep(64'hFFFF_FFFF_FFFF_FFFF, 2'd3), ones);
    chk("R3", "sgt_pos_over_minus1", take_br, 1'b1);
    // R4: unsigned: 0x80 greater than 0x01; op 3 never true
    run("R4", 2'd2, 2'd0, rep(64'h80, 2'd0), rep(64'h01, 2'd0), ones);
    chk("R4", "ugt_take", take_br, 1'b1);
    run("R4", 2'd3, 2'd1, rep(64'h5, 2'd1), rep(64'h5, 2'd1), ones);
    chk("R4", "none_skip", skip_br, 1'b1);
    // R5: zero test vector sets both flags, taken wins
    run("R5", 2'd0, 2'd2, rep(64'h7, 2'd2), rep(64'h9, 2'd2), '0);
    chk("R5", "zero_tst_zf", zf, 1'b1);
    chk("R6", "zero_tst_take", take_br, 1'b1);
    // R5: partial test vector covering only the faulty lane
    va = rep(64'hAB, 2'd0); vb = va; va[15:8] = 8'h00;
    run("R5", 2'd0, 2'd0, va, vb, {{(VW-16){1'b0}}, 16'hFF00});
    chk("R5", "partial_skip", skip_br, 1'b1);
    // R8: single-bit fault in one lane raises recover
    va = rep(64'hCAFE, 2'd1); vb = va; va[37] = ~va[37];
    run("R8", 2'd0, 2'd1, va, vb, ones);
    chk("R8", "fault_recover", recover, 1'b1);
    // R7: idle cycle keeps flags, clears decisions
    hz = zf; hc = cf;
    @(negedge clk);
    chk("R7", "idle_valid", res_valid, 1'b0);
    chk("R7", "idle_recover", recover, 1'b0);
    chk("R7", "idle_zf_hold", zf, hz);
    chk("R7", "idle_cf_hold", cf, hc);

    // random: replicated operands, occasional single-bit fault
    for (int k = 0; k < 400; k++) begin
      s  = 2'($urandom_range(0, 3));
      o  = 2'($urandom_range(0, 3));
      e  = {$urandom, $urandom};
      va = rep(e, s);
      vb = ($urandom_range(0, 3) == 0) ? va : rep({$urandom, $urandom}, s);
      tv = ($urandom_range(0, 4) == 0) ? {8{$urandom}} : ones;
      if ($urandom_range(0, 3) == 0) va[$urandom_range(0, VW-1)] ^= 1'b1;
      run((va == rep(e, s) && tv == ones) ? "R8" : "R6", o, s, va, vb, tv);
      if ($urandom_range(0, 5) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule